// File: doc/BRIEF.md
# System Management RAM Window Control

This block holds the one-byte control register that decides whether the 128 KB system-management memory window is open. The window covers addresses 0xA0000 to 0xBFFFF. Software writes and reads the register through a byte-wide configuration port. A layout input picks one of two bit layouts for the register. In the newer layout, two control bits must both be set to open the window. In the older layout, a single bit opens it. Each layout has its own mask of writable bits and its own reset value.

Downstream memory routing presents an access address to the block. One cycle later the block reports two things: whether the address falls inside the window, and whether the access should go to internal memory or to the external bus. An access goes to internal memory only when the window is open. A fixed system-management base address is also driven out.

The open flag is re-evaluated only when a write changes the bits that decide it. A change of the layout input on its own leaves the flag as it was.

Top module: `smram_window_ctl`

## Requirements
- R1: A synchronous reset sets the register to 0x02 when `layout_new` is 1 and to 0x00 when it is 0, and clears `win_open`, `acc_in_window` and `acc_internal`.
- R2: On a write, the register stores `cfg_wdata & 0x7F` in the newer layout and `cfg_wdata & 0x3F` in the older layout. The stored value appears on `cfg_rdata` after the capturing clock edge.
- R3: In the newer layout (`layout_new`=1), a write that re-evaluates the flag sets `win_open` only when bit 6 and bit 3 of the written byte are both 1.
- R4: In the older layout (`layout_new`=0), a write that re-evaluates the flag sets `win_open` exactly when bit 5 of the written byte is 1.
- R5: `win_open` is re-evaluated only by a write that changes a deciding bit of the current layout (bits 6 and 3 in the newer layout, bit 5 in the older one). A write that leaves those bits equal, or a change of `layout_new` alone, leaves `win_open` unchanged.
- R6: `win_open` is registered: it takes its new value at the clock edge that captures the write, and not before.
- R7: `acc_in_window` is 1 one cycle after `acc_addr` lies in 0xA0000..0xBFFFF, and 0 otherwise.
- R8: `acc_internal` is 1 one cycle after an in-window address while the window is open, and 0 otherwise. An access outside the window, or any access while the window is closed, goes external.
- R9: `smm_base` always reads 0xA0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layout_new | input | 1 | 1 selects the newer register layout, 0 the older one |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| acc_addr | input | 20 | Address of the access to classify |
| win_open | output | 1 | Window-open flag |
| acc_in_window | output | 1 | Previous cycle's address lay inside the window |
| acc_internal | output | 1 | Previous cycle's access routes to internal memory |
| smm_base | output | 20 | Fixed system-management base address |

## Verification
The hardest state to reach is a window-open flag that no longer matches what the register would decode to under the current layout. To get there, the bench opens the window in one layout and then flips `layout_new`. It then writes values that leave the new layout's deciding bit unchanged while other bits change. Finally it writes a value that does toggle that bit, and checks that only this write re-evaluates the flag.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned CFG_W = 8;
  typedef logic [CFG_W-1:0] cfg_t;

  // bits software may set, per layout
  function automatic cfg_t wr_mask(input logic newl);
    return newl ? cfg_t'(8'h7F) : cfg_t'(8'h3F);
  endfunction

  function automatic cfg_t rst_val(input logic newl);
    return newl ? cfg_t'(8'h02) : cfg_t'(8'h00);
  endfunction

  // bits whose change triggers re-evaluation of the open flag
  function automatic cfg_t decide_bits(input logic newl);
    return newl ? cfg_t'(8'h48) : cfg_t'(8'h20);
  endfunction

  function automatic logic opens(input logic newl, input cfg_t v);
    return newl ? (v[6] & v[3]) : v[5];
  endfunction
endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic layout_new,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t reg_q
);
  always_ff @(posedge clk) begin
    if (rst)     reg_q <= rst_val(layout_new);
    else if (we) reg_q <= wdata & wr_mask(layout_new);
  end

  logic rst_d, lay_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    lay_d <= layout_new;
  end

  // R1: value leaving reset matches the layout seen at reset
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_value: assert (reg_q == rst_val(lay_d));
    end
  end

  // R2: no bit outside the writable mask survives a write
  a_r2_masked: assert property (@(posedge clk) disable iff (rst)
    we |=> ((reg_q & ~$past(wr_mask(layout_new))) == '0));
endmodule

// File: rtl/smram_open_track.sv
module smram_open_track
  import smram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic layout_new,
  input  logic we,
  input  cfg_t wdata,
  input  cfg_t reg_q,
  output logic win_open
);
  logic changed;
  assign changed = |((wdata ^ reg_q) & decide_bits(layout_new));

  always_ff @(posedge clk) begin
    if (rst)                win_open <= 1'b0;
    else if (we && changed) win_open <= opens(layout_new, wdata);
  end

  // R5: without a deciding-bit change the flag holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && changed) |=> $stable(win_open));

  // R3: newer layout needs both bits
  a_r3_both_bits: assert property (@(posedge clk) disable iff (rst)
    (we && changed && layout_new) |=> (win_open == ($past(wdata[6]) && $past(wdata[3]))));

  // R4: older layout follows bit 5
  a_r4_bit5: assert property (@(posedge clk) disable iff (rst)
    (we && changed && !layout_new) |=> (win_open == $past(wdata[5])));
endmodule

// File: rtl/smram_addr_route.sv
module smram_addr_route #(
  parameter int unsigned          ADDR_W   = 20,
  parameter logic [ADDR_W-1:0]    WIN_BASE = 20'hA0000,
  parameter logic [ADDR_W-1:0]    WIN_SIZE = 20'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_open,
  output logic              in_win,
  output logic              internal
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic hit;
  assign hit = (addr >= WIN_BASE) && ({1'b0, addr} < WIN_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_win   <= 1'b0;
      internal <= 1'b0;
    end else begin
      in_win   <= hit;
      internal <= hit & win_open;
    end
  end

  // R8: internal routing only for window addresses
  a_r8_internal_in_window: assert property (@(posedge clk) disable iff (rst)
    internal |-> in_win);

  // R8: closed window sends the next access external
  a_r8_closed_external: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> !internal);
endmodule

// File: rtl/smram_window_ctl.sv
module smram_window_ctl
  import smram_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 20'h20000,
  parameter logic [ADDR_W-1:0] SMM_BASE = 20'hA0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              layout_new,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              win_open,
  output logic              acc_in_window,
  output logic              acc_internal,
  output logic [ADDR_W-1:0] smm_base
);
  cfg_t reg_q;

  smram_cfg_reg u_reg (
    .clk(clk), .rst(rst), .layout_new(layout_new),
    .we(cfg_we), .wdata(cfg_wdata), .reg_q(reg_q)
  );

  smram_open_track u_open (
    .clk(clk), .rst(rst), .layout_new(layout_new),
    .we(cfg_we), .wdata(cfg_wdata), .reg_q(reg_q), .win_open(win_open)
  );

  smram_addr_route #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_route (
    .clk(clk), .rst(rst), .addr(acc_addr), .win_open(win_open),
    .in_win(acc_in_window), .internal(acc_internal)
  );

  assign cfg_rdata = reg_q;
  assign smm_base  = SMM_BASE;
endmodule

// File: tb/tb_smram_window_ctl.sv
`timescale 1ns/1ps
module tb_smram_window_ctl;
  logic clk = 1'b0;
  logic rst, layout_new, cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [19:0] acc_addr, smm_base;
  logic win_open, acc_in_window, acc_internal;

  always #2.5 clk = ~clk;

  smram_window_ctl dut (
    .clk(clk), .rst(rst), .layout_new(layout_new), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .win_open(win_open), .acc_in_window(acc_in_window),
    .acc_internal(acc_internal), .smm_base(smm_base)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic lay, input logic [7:0] d);
    layout_new = lay; cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic route(input logic [19:0] a, input logic exp_in, input logic exp_int, input string tag);
    acc_addr = a;
    @(posedge clk); @(negedge clk);
    chk(acc_in_window == exp_in, {tag, " R7 in_window"}, acc_in_window, exp_in);
    chk(acc_internal == exp_int, {tag, " R8 internal"}, acc_internal, exp_int);
  endtask

  task automatic do_reset(input logic lay);
    rst = 1'b1; layout_new = lay; cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // {layout, wdata, expected rdata, expected win_open}; applied in order from the newer-layout reset state
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 8'h48, 8'h48, 1'b1},
    {1'b1, 8'h40, 8'h40, 1'b0},
    {1'b1, 8'h08, 8'h08, 1'b0},
    {1'b1, 8'hFF, 8'h7F, 1'b1},
    {1'b1, 8'hC8, 8'h48, 1'b1},
    {1'b1, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h20, 8'h20, 1'b1},
    {1'b0, 8'hFF, 8'h3F, 1'b1},
    {1'b0, 8'hDF, 8'h1F, 1'b0},
    {1'b0, 8'h48, 8'h08, 1'b0},
    {1'b1, 8'h40, 8'h40, 1'b0},
    {1'b1, 8'h48, 8'h48, 1'b1},
    {1'b0, 8'h08, 8'h08, 1'b1},
    {1'b0, 8'h28, 8'h28, 1'b1},
    {1'b0, 8'h00, 8'h00, 1'b0}
  };

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    acc_addr = 20'h0; cfg_wdata = 8'h0;
    // R1: older-layout reset
    do_reset(1'b0);
    chk(cfg_rdata == 8'h00, "R1 old reset value", cfg_rdata, 8'h00);
    chk(win_open == 1'b0, "R1 old reset closed", win_open, 0);
    // R1: newer-layout reset
    do_reset(1'b1);
    chk(cfg_rdata == 8'h02, "R1 new reset value", cfg_rdata, 8'h02);
    chk(win_open == 1'b0, "R1 new reset closed", win_open, 0);
    chk(acc_internal == 1'b0 && acc_in_window == 1'b0, "R1 route cleared", {acc_in_window, acc_internal}, 0);
    chk(smm_base == 20'hA0000, "R9 base after reset", smm_base, 20'hA0000);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17], VEC[i][16:9]);
      chk(cfg_rdata == VEC[i][8:1], $sformatf("R2 rdata vec %0d", i), cfg_rdata, VEC[i][8:1]);
      chk(win_open == VEC[i][0], $sformatf("R3 R4 R5 open vec %0d", i), win_open, VEC[i][0]);
    end

    // R7 R8 with window open
    wr(1'b1, 8'h48);
    route(20'hA0000, 1'b1, 1'b1, "open low edge");
    route(20'hBFFFF, 1'b1, 1'b1, "open high edge");
    route(20'hC0000, 1'b0, 1'b0, "open above");
    route(20'h9FFFF, 1'b0, 1'b0, "open below");
    // R8 window closed
    wr(1'b1, 8'h00);
    route(20'hA0000, 1'b1, 1'b0, "closed low");
    route(20'hB1234, 1'b1, 1'b0, "closed mid");

    // R5: layout change alone keeps flag
    wr(1'b1, 8'h48);
    layout_new = 1'b0;
    repeat (3) @(negedge clk);
    chk(win_open == 1'b1, "R5 layout flip holds open", win_open, 1);
    chk(cfg_rdata == 8'h48, "R5 layout flip keeps reg", cfg_rdata, 8'h48);

    // R6: flag changes at the capturing edge, not before
    layout_new = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h00;
    #1;
    chk(win_open == 1'b1, "R6 before edge", win_open, 1);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    chk(win_open == 1'b0, "R6 after edge", win_open, 0);

    chk(smm_base == 20'hA0000, "R9 base at end", smm_base, 20'hA0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule